// File: doc/BRIEF.md
# Hash-Chained Stream ID Table

This block translates a 16-bit PCIe requester ID (bus, device and function) into an 8-bit stream ID offset. It keeps a 256-slot table in on-chip flops. Each slot packs a requester ID, a stream ID offset and a link index. The slot for a requester ID comes from a CRC-8 hash of that ID. When two IDs land on the same slot, the later one is placed by linear probing. A link field chains the probed slots together so that a later lookup can follow them.

Three commands share one ready signal, and only one operation runs at a time.

- **Clear** zeroes every slot. It runs over 256 cycles.
- **Insert** hashes the requester ID, walks forward to the first empty slot, links the occupied slots it passes, and writes the new entry.
- **Lookup** hashes the requester ID and follows the chain. It returns the stored stream ID offset with a hit flag, or it reports a miss.

Each finished operation produces a single-cycle `done` pulse, with its results held on the result outputs.

Top module: `sidt_table`

## Requirements
- R1: The home slot of a requester ID is a CRC-8 with generator 0x07, computed MSB first with a start value of zero and no output inversion, over the high byte of the ID followed by the low byte. For example, ID 0x0001 hashes to 0x07 and ID 0x0100 hashes to 0x15.
- R2: A slot is 32 bits: requester ID in [31:16], stream ID offset in [15:8], link index in [7:0]. A slot that is all zeros is empty. A newly written entry always has a link index of zero. A lookup that hits returns the stored offset on `done_sid` and the slot number on `done_idx`.
- R3: Clear writes zero to every slot. The `done` pulse for a clear becomes visible 256 cycles after the accepting edge, and `busy` stays high for that whole time.
- R4: When an insert finds its home slot occupied, it moves to the next index, wrapping from 255 to 0, until it finds an empty slot. `done_idx` reports the slot that was written, with `done_err` low.
- R5: Each occupied slot that an insert passes and whose link index is zero gets its link index set to (its own index + 1) mod 256, with its other fields unchanged. A lookup follows a non-zero link after a requester ID mismatch. As a consequence, slot 255 can never link to slot 0.
- R6: A lookup reports a miss (`done_hit` = 0) when it reaches an empty slot, or when a mismatching slot has a link index of zero.
- R7: An insert that has found all 256 slots occupied ends with `done_err` = 1 and `done_hit` = 0, and it adds no entry.
- R8: `cmd_ready` is high only while no operation is running. When several command valids are high in the same cycle, clear wins over insert, and insert wins over lookup. The command that loses is dropped and produces no `done`.
- R9: `busy` goes high in the cycle after a command is accepted and falls in the cycle that `done` pulses. `done` is high for one cycle per operation. After reset, `busy` and `done` are low and `cmd_ready` is high.
- R10: A lookup ends within 256 table steps, even on a full table.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| clr_valid | input | 1 | Request to clear the whole table |
| ins_valid | input | 1 | Request to insert a mapping |
| ins_rid | input | 16 | Requester ID to insert |
| ins_sid | input | 8 | Stream ID offset to store |
| lk_valid | input | 1 | Request to look up a requester ID |
| lk_rid | input | 16 | Requester ID to look up |
| cmd_ready | output | 1 | High when a command can be accepted |
| busy | output | 1 | High while an operation is running |
| done | output | 1 | One-cycle completion pulse |
| done_hit | output | 1 | Lookup found the requester ID |
| done_err | output | 1 | Insert found no free slot |
| done_sid | output | 8 | Stream ID offset from a lookup hit |
| done_idx | output | 8 | Slot written by an insert or found by a lookup |

## Verification
The bench builds the block with its default parameters: 16-bit requester IDs, 8-bit stream IDs and an 8-bit index, which gives the full 256-slot table. At that size the bench can search for requester IDs that hash to a chosen slot, including slot 255. This lets it force collisions, the wrap from 255 to 0, and the link that cannot cross that wrap. Filling all 256 slots also fits within the cycle budget, so the out-of-space error and the bounded lookup on a full table are both reached.

// File: rtl/sidt_pkg.sv
package sidt_pkg;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_CLR,
    ST_INS,
    ST_LK
  } sidt_state_e;

  typedef enum logic [1:0] {
    OP_NONE,
    OP_CLR,
    OP_INS,
    OP_LK
  } sidt_op_e;

  // Fixed command priority: clear, then insert, then lookup.
  function automatic sidt_op_e pick_op(input logic clr, input logic ins, input logic lk);
    if (clr)      return OP_CLR;
    else if (ins) return OP_INS;
    else if (lk)  return OP_LK;
    else          return OP_NONE;
  endfunction

endpackage

// File: rtl/sidt_hash.sv
module sidt_hash #(
  parameter int          RID_W = 16,
  parameter int          H_W   = 8,
  parameter logic [7:0]  POLY  = 8'h07
) (
  input  logic [RID_W-1:0] rid,
  output logic [H_W-1:0]   hash
);

  // Serial CRC, MSB first, zero start value, no output inversion.
  // Feeding the ID bit by bit from the top covers the high byte first.
  function automatic logic [H_W-1:0] crc_bits(input logic [RID_W-1:0] d);
    logic [H_W-1:0] c;
    logic           fb;
    c = '0;
    for (int i = RID_W - 1; i >= 0; i--) begin
      fb = c[H_W-1] ^ d[i];
      c  = {c[H_W-2:0], 1'b0} ^ (fb ? POLY[H_W-1:0] : '0);
    end
    return c;
  endfunction

  assign hash = crc_bits(rid);

endmodule

// File: rtl/sidt_store.sv
module sidt_store #(
  parameter int IDX_W = 8,
  parameter int ENT_W = 32
) (
  input  logic             clk,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [ENT_W-1:0] wr_data,
  input  logic [IDX_W-1:0] rd_idx,
  output logic [ENT_W-1:0] rd_data
);

  localparam int DEPTH = 1 << IDX_W;

  logic [ENT_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_idx] <= wr_data;
  end

  assign rd_data = mem[rd_idx];

endmodule

// File: rtl/sidt_ctrl.sv
module sidt_ctrl
  import sidt_pkg::*;
#(
  parameter int RID_W = 16,
  parameter int SID_W = 8,
  parameter int IDX_W = 8
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  sidt_op_e                     acc_op,
  input  logic [IDX_W-1:0]             acc_hash,
  input  logic [RID_W-1:0]             acc_rid,
  input  logic [SID_W-1:0]             acc_sid,
  input  logic [RID_W+SID_W+IDX_W-1:0] rd_data,
  output logic [IDX_W-1:0]             ptr,
  output logic                         wr_en,
  output logic [IDX_W-1:0]             wr_idx,
  output logic [RID_W+SID_W+IDX_W-1:0] wr_data,
  output logic                         cmd_ready,
  output logic                         busy,
  output logic                         done,
  output logic                         done_hit,
  output logic                         done_err,
  output logic [SID_W-1:0]             done_sid,
  output logic [IDX_W-1:0]             done_idx
);

  localparam int RID_LSB = SID_W + IDX_W;
  localparam int ENT_W   = RID_W + SID_W + IDX_W;

  function automatic logic [ENT_W-1:0] pack_entry(input logic [RID_W-1:0] r,
                                                  input logic [SID_W-1:0] s,
                                                  input logic [IDX_W-1:0] n);
    return {r, s, n};
  endfunction

  sidt_state_e      state;
  logic [IDX_W-1:0] steps;
  logic [RID_W-1:0] key_rid;
  logic [SID_W-1:0] key_sid;

  // Named views of the slot under the pointer.
  logic [RID_W-1:0] rd_rid;
  logic [SID_W-1:0] rd_sid;
  logic [IDX_W-1:0] rd_nxt;
  logic             rd_empty, rd_match, last_step, take;

  assign rd_rid    = rd_data[RID_LSB +: RID_W];
  assign rd_sid    = rd_data[IDX_W +: SID_W];
  assign rd_nxt    = rd_data[IDX_W-1:0];
  assign rd_empty  = (rd_data == '0);
  assign rd_match  = (rd_rid == key_rid);
  assign last_step = (steps == '1);
  assign cmd_ready = (state == ST_IDLE);
  assign busy      = !cmd_ready;
  assign take      = cmd_ready && (acc_op != OP_NONE);

  always_comb begin
    wr_en   = 1'b0;
    wr_idx  = ptr;
    wr_data = '0;
    unique case (state)
      ST_CLR: wr_en = 1'b1;
      ST_INS: begin
        if (rd_empty) begin
          wr_en   = 1'b1;
          wr_data = pack_entry(key_rid, key_sid, '0);
        end else if (rd_nxt == '0) begin
          wr_en   = 1'b1;
          wr_data = pack_entry(rd_rid, rd_sid, ptr + 1'b1);
        end
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      ptr      <= '0;
      steps    <= '0;
      key_rid  <= '0;
      key_sid  <= '0;
      done     <= 1'b0;
      done_hit <= 1'b0;
      done_err <= 1'b0;
      done_sid <= '0;
      done_idx <= '0;
    end else begin
      done <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          if (take) begin
            key_rid <= acc_rid;
            key_sid <= acc_sid;
            steps   <= '0;
            ptr     <= (acc_op == OP_CLR) ? '0 : acc_hash;
            state   <= (acc_op == OP_CLR) ? ST_CLR :
                       (acc_op == OP_INS) ? ST_INS : ST_LK;
          end
        end
        ST_CLR: begin
          ptr <= ptr + 1'b1;
          if (ptr == '1) begin
            state    <= ST_IDLE;
            done     <= 1'b1;
            done_hit <= 1'b0;
            done_err <= 1'b0;
            done_sid <= '0;
            done_idx <= '0;
          end
        end
        ST_INS: begin
          if (rd_empty || last_step) begin
            state    <= ST_IDLE;
            done     <= 1'b1;
            done_hit <= 1'b0;
            done_err <= !rd_empty;
            done_sid <= '0;
            done_idx <= ptr;
          end else begin
            ptr   <= ptr + 1'b1;
            steps <= steps + 1'b1;
          end
        end
        ST_LK: begin
          if (!rd_empty && rd_match) begin
            state    <= ST_IDLE;
            done     <= 1'b1;
            done_hit <= 1'b1;
            done_err <= 1'b0;
            done_sid <= rd_sid;
            done_idx <= ptr;
          end else if (rd_empty || rd_nxt == '0 || last_step) begin
            state    <= ST_IDLE;
            done     <= 1'b1;
            done_hit <= 1'b0;
            done_err <= 1'b0;
            done_sid <= '0;
            done_idx <= ptr;
          end else begin
            ptr   <= rd_nxt;
            steps <= steps + 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/sidt_table.sv
module sidt_table
  import sidt_pkg::*;
#(
  parameter int         RID_W = 16,
  parameter int         SID_W = 8,
  parameter int         IDX_W = 8,
  parameter logic [7:0] POLY  = 8'h07
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr_valid,
  input  logic             ins_valid,
  input  logic [RID_W-1:0] ins_rid,
  input  logic [SID_W-1:0] ins_sid,
  input  logic             lk_valid,
  input  logic [RID_W-1:0] lk_rid,
  output logic             cmd_ready,
  output logic             busy,
  output logic             done,
  output logic             done_hit,
  output logic             done_err,
  output logic [SID_W-1:0] done_sid,
  output logic [IDX_W-1:0] done_idx
);

  localparam int ENT_W = RID_W + SID_W + IDX_W;

  sidt_op_e         sel_op;
  logic [RID_W-1:0] sel_rid;
  logic [IDX_W-1:0] sel_hash;
  logic [IDX_W-1:0] ptr;
  logic [ENT_W-1:0] rd_data;
  logic             wr_en;
  logic [IDX_W-1:0] wr_idx;
  logic [ENT_W-1:0] wr_data;

  // Named events for the checker.
  logic accept;
  logic acc_clr;

  assign sel_op  = pick_op(clr_valid, ins_valid, lk_valid);
  assign sel_rid = (sel_op == OP_INS) ? ins_rid : lk_rid;
  assign accept  = cmd_ready && (sel_op != OP_NONE);
  assign acc_clr = accept && (sel_op == OP_CLR);

  sidt_hash #(.RID_W(RID_W), .H_W(IDX_W), .POLY(POLY)) u_hash (
    .rid  (sel_rid),
    .hash (sel_hash)
  );

  sidt_store #(.IDX_W(IDX_W), .ENT_W(ENT_W)) u_store (
    .clk     (clk),
    .wr_en   (wr_en),
    .wr_idx  (wr_idx),
    .wr_data (wr_data),
    .rd_idx  (ptr),
    .rd_data (rd_data)
  );

  sidt_ctrl #(.RID_W(RID_W), .SID_W(SID_W), .IDX_W(IDX_W)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .acc_op    (sel_op),
    .acc_hash  (sel_hash),
    .acc_rid   (sel_rid),
    .acc_sid   (ins_sid),
    .rd_data   (rd_data),
    .ptr       (ptr),
    .wr_en     (wr_en),
    .wr_idx    (wr_idx),
    .wr_data   (wr_data),
    .cmd_ready (cmd_ready),
    .busy      (busy),
    .done      (done),
    .done_hit  (done_hit),
    .done_err  (done_err),
    .done_sid  (done_sid),
    .done_idx  (done_idx)
  );

endmodule

// File: rtl/sidt_table_chk.sv
module sidt_table_chk #(
  parameter int IDX_W = 8
) (
  input logic clk,
  input logic rst_n,
  input logic accept,
  input logic acc_clr,
  input logic cmd_ready,
  input logic busy,
  input logic done,
  input logic done_hit,
  input logic done_err
);

  localparam int DEPTH = 1 << IDX_W;

  logic [IDX_W+1:0] run_cnt;
  logic             clr_run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_cnt <= '0;
      clr_run <= 1'b0;
    end else if (accept) begin
      run_cnt <= '0;
      clr_run <= acc_clr;
    end else if (busy) begin
      run_cnt <= run_cnt + 1'b1;
    end
  end

  a_r8_busy_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> busy);

  a_r8_no_accept_busy: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !accept);

  a_r8_ready_idle: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_ready |-> !busy);

  a_r9_done_releases: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  a_r9_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r7_flags_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !(done_hit && done_err));

  a_r3_clear_length: assert property (@(posedge clk) disable iff (!rst_n)
    (done && clr_run) |-> (run_cnt == (IDX_W + 2)'(DEPTH)));

  a_r10_bounded_walk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (run_cnt <= (IDX_W + 2)'(DEPTH)));

endmodule

bind sidt_table sidt_table_chk #(.IDX_W(IDX_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .accept    (accept),
  .acc_clr   (acc_clr),
  .cmd_ready (cmd_ready),
  .busy      (busy),
  .done      (done),
  .done_hit  (done_hit),
  .done_err  (done_err)
);

// File: tb/tb_sidt_table.sv
module tb_sidt_table;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        clr_valid = 1'b0, ins_valid = 1'b0, lk_valid = 1'b0;
  logic [15:0] ins_rid = '0, lk_rid = '0;
  logic [7:0]  ins_sid = '0;
  logic        cmd_ready, busy, done, done_hit, done_err;
  logic [7:0]  done_sid, done_idx;

  always #2 clk = ~clk;

  sidt_table dut (
    .clk(clk), .rst_n(rst_n), .clr_valid(clr_valid), .ins_valid(ins_valid),
    .ins_rid(ins_rid), .ins_sid(ins_sid), .lk_valid(lk_valid), .lk_rid(lk_rid),
    .cmd_ready(cmd_ready), .busy(busy), .done(done), .done_hit(done_hit),
    .done_err(done_err), .done_sid(done_sid), .done_idx(done_idx)
  );

  int tests = 0;
  int fails = 0;
  bit finished = 0;

  typedef struct {
    bit         hit;
    bit         err;
    logic [7:0] sid;
    logic [7:0] idx;
    bit         chk_idx;
    string      req;
  } exp_t;

  exp_t        q[$];
  logic [31:0] model [256];

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // Reference hash: remainder of (rid * x^8) divided by x^8+x^2+x+1.
  function automatic logic [7:0] ref_hash(input logic [15:0] rid);
    logic [23:0] r;
    r = {rid, 8'h00};
    for (int b = 23; b >= 8; b--)
      if (r[b]) r[b -: 9] = r[b -: 9] ^ 9'h107;
    return r[7:0];
  endfunction

  function automatic logic [15:0] find_rid(input logic [7:0] h, input logic [15:0] skip);
    for (int r = 1; r < 65536; r++)
      if (ref_hash(16'(r)) == h && 16'(r) != skip) return 16'(r);
    return 16'h0;
  endfunction

  function automatic exp_t model_insert(input logic [15:0] rid, input logic [7:0] sid,
                                        input string req);
    exp_t       e;
    logic [7:0] p;
    e = '{hit: 0, err: 1, sid: 8'h0, idx: 8'h0, chk_idx: 0, req: req};
    p = ref_hash(rid);
    for (int n = 0; n < 256; n++) begin
      if (model[p] == 32'h0) begin
        model[p] = {rid, sid, 8'h00};
        e.err = 0; e.idx = p; e.chk_idx = 1;
        return e;
      end
      if (model[p][7:0] == 8'h00) model[p][7:0] = p + 8'd1;
      p = p + 8'd1;
    end
    return e;
  endfunction

  function automatic exp_t model_lookup(input logic [15:0] rid, input string req);
    exp_t       e;
    logic [7:0] p;
    e = '{hit: 0, err: 0, sid: 8'h0, idx: 8'h0, chk_idx: 0, req: req};
    p = ref_hash(rid);
    for (int n = 0; n < 256; n++) begin
      if (model[p] == 32'h0) return e;
      if (model[p][31:16] == rid) begin
        e.hit = 1; e.sid = model[p][15:8]; e.idx = p; e.chk_idx = 1;
        return e;
      end
      if (model[p][7:0] == 8'h00) return e;
      p = model[p][7:0];
    end
    return e;
  endfunction

  // Monitor: compare each completion against the scoreboard queue.
  always @(negedge clk) begin
    if (rst_n && done) begin
      if (q.size() == 0) begin
        chk(0, "R8", "unexpected done", 1, 0);
      end else begin
        exp_t e;
        e = q.pop_front();
        chk(done_hit == e.hit, e.req, "done_hit", done_hit, e.hit);
        chk(done_err == e.err, e.req, "done_err", done_err, e.err);
        if (e.hit) chk(done_sid == e.sid, e.req, "done_sid", done_sid, e.sid);
        if (e.chk_idx) chk(done_idx == e.idx, e.req, "done_idx", done_idx, e.idx);
      end
    end
  end

  // Driver: priority clear > insert > lookup, as in R8.
  task automatic issue(input bit c, input bit i, input bit l,
                       input logic [15:0] ri, input logic [7:0] si,
                       input logic [15:0] rl, input string req, output int cyc);
    if (c) begin
      for (int k = 0; k < 256; k++) model[k] = 32'h0;
      q.push_back('{hit: 0, err: 0, sid: 8'h0, idx: 8'h0, chk_idx: 0, req: req});
    end else if (i) begin
      q.push_back(model_insert(ri, si, req));
    end else begin
      q.push_back(model_lookup(rl, req));
    end
    @(negedge clk);
    chk(cmd_ready == 1'b1, "R8", "ready before command", cmd_ready, 1);
    clr_valid = c; ins_valid = i; lk_valid = l;
    ins_rid = ri; ins_sid = si; lk_rid = rl;
    @(posedge clk);
    @(negedge clk);
    clr_valid = 0; ins_valid = 0; lk_valid = 0;
    chk(busy == 1'b1 && cmd_ready == 1'b0, "R9", "busy after accept",
        {busy, cmd_ready}, 2'b10);
    cyc = 0;
    do begin
      @(negedge clk);
      cyc++;
    end while (!done);
  endtask

  task automatic do_clear();
    int cyc;
    issue(1, 0, 0, 16'h0, 8'h0, 16'h0, "R3", cyc);
    chk(cyc == 256, "R3", "clear cycles", cyc, 256);
  endtask

  task automatic do_ins(input logic [15:0] r, input logic [7:0] s, input string req);
    int cyc;
    issue(0, 1, 0, r, s, 16'h0, req, cyc);
  endtask

  task automatic do_lk(input logic [15:0] r, input string req);
    int cyc;
    issue(0, 0, 1, 16'h0, 8'h0, r, req, cyc);
    chk(cyc <= 256, "R10", "lookup cycles", cyc, 256);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    logic [15:0] a, b, c;
    logic [7:0]  h;
    int          cyc;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(busy == 0 && done == 0 && cmd_ready == 1, "R9", "reset state",
        {busy, done, cmd_ready}, 3'b001);

    // R1: literal hash values, checked against the slot an insert picks.
    chk(ref_hash(16'h0001) == 8'h07, "R1", "ref hash 0001", ref_hash(16'h0001), 8'h07);
    chk(ref_hash(16'h0100) == 8'h15, "R1", "ref hash 0100", ref_hash(16'h0100), 8'h15);
    do_clear();
    do_lk(16'h1234, "R6");
    do_ins(16'h0001, 8'h11, "R1");
    do_ins(16'h0100, 8'h22, "R1");
    do_ins(16'hABCD, 8'h3C, "R1");
    do_lk(16'h0100, "R2");
    do_lk(16'hABCD, "R2");
    do_lk(16'h0001, "R2");

    // R4 / R5: collision on the home slot of ABCD.
    h = ref_hash(16'hABCD);
    b = find_rid(h, 16'hABCD);
    c = find_rid(h, b);
    if (c == 16'hABCD) c = find_rid(h, 16'hABCD + 16'd0) + 16'd0;
    do_ins(b, 8'h4D, "R4");
    do_lk(b, "R5");
    begin
      logic [15:0] d;
      d = 16'h1;
      while (ref_hash(d) != h || d == b || d == 16'hABCD) d++;
      do_lk(d, "R6");
    end

    // Wrap from slot 255 to slot 0; the chain cannot cross it.
    do_clear();
    a = find_rid(8'hFF, 16'h0);
    b = find_rid(8'hFF, a);
    do_ins(a, 8'h01, "R4");
    do_ins(b, 8'h02, "R4");
    do_lk(a, "R2");
    do_lk(b, "R5");

    // Priority: insert beats lookup; the lookup yields no done.
    issue(0, 1, 1, 16'h0777, 8'h77, 16'h0778, "R8", cyc);
    repeat (4) begin
      @(negedge clk);
      chk(done == 0, "R8", "dropped lookup done", done, 0);
    end
    do_lk(16'h0777, "R8");
    // Priority: clear beats insert.
    issue(1, 1, 0, 16'h0999, 8'h99, 16'h0, "R8", cyc);
    chk(cyc == 256, "R3", "clear cycles with insert", cyc, 256);
    do_lk(16'h0999, "R8");

    // Full table.
    do_clear();
    for (int r = 1; r <= 256; r++) do_ins(16'(r), 8'h5A, "R4");
    do_ins(16'h8001, 8'h66, "R7");
    do_lk(16'h8001, "R7");
    do_lk(16'd200, "R10");
    do_lk(16'h4444, "R10");

    repeat (4) @(negedge clk);
    chk(q.size() == 0, "R9", "pending completions", q.size(), 0);
    finished = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule